// File: doc/BRIEF.md
# Timer Event Flags with Read-Arm Clearing

This block pairs a 16-bit up-counter with two compare registers and one capture-event input. It keeps four sticky event flags in one status register. The counter advances on each cycle where the count-enable tick is high. Hardware sets a flag when its event occurs: a counter wrap, a match on either compare register, or a rising edge on the capture input. Each flag drives its own interrupt request, and a separate enable register gates each request.

Software can never set a flag. To clear one, software must first read the status register while that flag reads 1, which arms the flag. A later write of 0 to that bit then clears it. A write of 0 to a flag that is not armed changes nothing. The capture input comes from outside the clock domain, so it passes through a two-stage synchronizer and then an edge detector. A pulse of any length therefore sets the capture flag once.

The CPU register bus is made of an address, a read strobe, a write strobe, write data and read data. Read data is combinational from the address.

Top module: `tmr_evt_flags`

## Requirements
- R1: After reset, the counter, both compare registers, the enable register and all four flags are 0, all interrupt requests are low, and the status register at address 3 reads 0xFFE1.
- R2: The counter at address 0 takes a bus write and advances by one on each cycle where tick is high. It holds its value when tick is low. Stepping from 0xFFFF to 0x0000 sets the wrap flag, status bit 1, on the same clock edge.
- R3: When a tick moves the counter to the value of compare register A (address 1), the match-A flag, status bit 3, is set on that edge.
- R4: When a tick moves the counter to the value of compare register B (address 2), the match-B flag, status bit 2, is set on that edge.
- R5: A rising edge on cap_in sets the capture flag, status bit 4, within four cycles. A level held high sets the flag only once.
- R6: Writing 1 to a flag bit never sets it. Writing to a flag that holds 0 leaves it 0.
- R7: Writing 0 to a set flag that has not been read as 1 since it was last armed leaves it set.
- R8: A read of the status register arms every flag that reads 1 in that cycle. A following write of 0 to an armed flag clears it and uses up the arm. A flag that was 0 when read is not armed by that read.
- R9: If a hardware set event and a software clear of the same flag fall in one cycle, the flag stays 1.
- R10: The enable register at address 4 holds one enable per flag at bits 4 (capture), 3 (match A), 2 (match B) and 1 (wrap). Each interrupt request is high exactly while its flag and its enable bit are both 1.
- R11: Status bits 0 and 15..5 read as 1, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe; a status read arms the flags that are set |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register |
| tick | input | 1 | Counter advance enable |
| cap_in | input | 1 | Capture event input, asynchronous |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmpa | output | 1 | Match-A interrupt request |
| irq_cmpb | output | 1 | Match-B interrupt request |
| irq_ovf | output | 1 | Wrap interrupt request |

## Verification
The assertions check four things on every cycle:
- a flag only rises after a hardware set event;
- a flag only falls after an armed status write;
- a set event always beats a clear in the same cycle;
- the counter holds without a tick and wraps to zero with the wrap flag set.

The bench scenarios cover the rest. They show that a compare match sets only its own flag, and that a long capture pulse sets its flag once. They also show that a 0 written without a prior read is ignored, and that a read made before a flag was set does not arm it. Finally, they check the constant-one readback of the unused status bits and the interrupt gating.

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
  parameter int CNT_W = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             tick,
  input  logic             cap_in,
  output logic             irq_cap,
  output logic             irq_cmpa,
  output logic             irq_cmpb,
  output logic             irq_ovf
);
  localparam logic [AW-1:0] A_CNT = AW'(0), A_CMPA = AW'(1), A_CMPB = AW'(2),
                            A_STAT = AW'(3), A_IE = AW'(4);
  localparam logic [CNT_W-1:0] FLAG_MASK = CNT_W'(5'b11110);

  logic [CNT_W-1:0] cnt, cmp_a, cmp_b, cnt_inc;
  logic [3:0]       flg, armed, ie, set_ev, clr;
  logic [2:0]       cap_sync;

  wire cnt_wr  = wr_en && addr == A_CNT;
  wire stat_wr = wr_en && addr == A_STAT;
  wire stat_rd = rd_en && addr == A_STAT;
  wire adv     = tick && !cnt_wr;

  assign cnt_inc = cnt + CNT_W'(1);
  // flag order: [3] capture, [2] match A, [1] match B, [0] wrap -> status bits 4..1
  assign set_ev = {cap_sync[1] & ~cap_sync[2],
                   adv && cnt_inc == cmp_a,
                   adv && cnt_inc == cmp_b,
                   adv && (&cnt)};
  assign clr = stat_wr ? (armed & ~wdata[4:1]) : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cmp_a    <= '0;
      cmp_b    <= '0;
      ie       <= '0;
      flg      <= '0;
      armed    <= '0;
      cap_sync <= '0;
    end else begin
      cap_sync <= {cap_sync[1:0], cap_in};
      if (cnt_wr)                       cnt   <= wdata;
      else if (tick)                    cnt   <= cnt_inc;
      if (wr_en && addr == A_CMPA)      cmp_a <= wdata;
      if (wr_en && addr == A_CMPB)      cmp_b <= wdata;
      if (wr_en && addr == A_IE)        ie    <= wdata[4:1];
      flg   <= (flg & ~clr) | set_ev;
      armed <= (armed & ~clr) | (stat_rd ? flg : 4'b0);
    end
  end

  always_comb begin
    case (addr)
      A_CNT:   rdata = cnt;
      A_CMPA:  rdata = cmp_a;
      A_CMPB:  rdata = cmp_b;
      A_STAT:  rdata = ~FLAG_MASK | CNT_W'({flg, 1'b0});
      A_IE:    rdata = CNT_W'({ie, 1'b0});
      default: rdata = '0;
    endcase
  end

  assign irq_cap  = flg[3] & ie[3];
  assign irq_cmpa = flg[2] & ie[2];
  assign irq_cmpb = flg[1] & ie[1];
  assign irq_ovf  = flg[0] & ie[0];

  AST_HW_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((flg & ~$past(flg) & ~$past(set_ev)) == 4'b0)); // R6
  AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((~flg & $past(flg) & ~($past(armed) & {4{$past(stat_wr)}})) == 4'b0)); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((~flg & $past(set_ev)) == 4'b0)); // R9
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (&cnt)) |=> (cnt == '0 && flg[0])); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt)); // R2
endmodule

// File: tb/sim_tmr_evt_flags.sv
`timescale 1ns/1ps
module sim_tmr_evt_flags;
  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0, tick = 0, cap_in = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic irq_cap, irq_cmpa, irq_cmpb, irq_ovf;
  int total = 0, bad = 0;
  bit done = 0;

  tmr_evt_flags u0 (.clk, .rst_n, .addr, .rd_en, .wr_en, .wdata, .rdata,
                    .tick, .cap_in, .irq_cap, .irq_cmpa, .irq_cmpb, .irq_ovf);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic clr_all();
    logic [15:0] d;
    rd(3, d); wr(3, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3, d); chk("R1 status", d, 16'hFFE1);
    rd(0, d); chk("R1 counter", d, 16'h0000);
    rd(4, d); chk("R1 enable", d, 16'h0000);
    chk("R1 irqs", {12'h0, irq_cap, irq_cmpa, irq_cmpb, irq_ovf}, 16'h0);
  endtask

  task automatic t_compare();
    logic [15:0] d;
    wr(1, 16'h0010); wr(2, 16'h0020); wr(0, 16'h000E);
    ticks(1); rd(3, d); chk("R3 before match", d, 16'hFFE1);
    ticks(1); rd(3, d); chk("R3 match A", d, 16'hFFE9);
    ticks(16); rd(0, d); chk("R2 count", d, 16'h0020);
    rd(3, d); chk("R4 match B", d, 16'hFFED);
    clr_all(); rd(3, d); chk("R8 clear both", d, 16'hFFE1);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    wr(0, 16'hFFFD); ticks(2);
    rd(3, d); chk("R2 no wrap yet", d, 16'hFFE1);
    repeat (3) @(negedge clk);
    rd(0, d); chk("R2 hold without tick", d, 16'hFFFF);
    ticks(1); rd(0, d); chk("R2 wrapped count", d, 16'h0000);
    rd(3, d); chk("R2 wrap flag", d, 16'hFFE3);
    clr_all();
  endtask

  task automatic t_sw_set();
    logic [15:0] d;
    wr(3, 16'hFFFF); rd(3, d); chk("R6 write ones", d, 16'hFFE1);
    wr(3, 16'h0000); rd(3, d); chk("R11 write zeros", d, 16'hFFE1);
  endtask

  task automatic t_arm();
    logic [15:0] d;
    wr(0, 16'hFFFF); ticks(1);
    wr(3, 16'h0000); rd(3, d); chk("R7 unread zero write", d, 16'hFFE3);
    wr(3, 16'h0000); rd(3, d); chk("R8 read then clear", d, 16'hFFE1);
    wr(0, 16'hFFFF); ticks(1);
    wr(3, 16'h0000); rd(3, d); chk("R8 arm used up", d, 16'hFFE3);
    clr_all();
    rd(3, d);
    wr(0, 16'h000F); ticks(1);
    wr(3, 16'h0000); rd(3, d); chk("R8 read before set", d, 16'hFFE9);
    clr_all();
  endtask

  task automatic t_capture();
    logic [15:0] d;
    @(negedge clk); cap_in = 1;
    repeat (5) @(negedge clk);
    rd(3, d); chk("R5 capture set", d, 16'hFFF1);
    wr(3, 16'h0000);
    repeat (6) @(negedge clk);
    rd(3, d); chk("R5 level sets once", d, 16'hFFE1);
    @(negedge clk); cap_in = 0;
    repeat (4) @(negedge clk); cap_in = 1;
    @(negedge clk); cap_in = 0;
    repeat (5) @(negedge clk);
    rd(3, d); chk("R5 short pulse", d, 16'hFFF1);
    clr_all();
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    wr(0, 16'hFFFF); ticks(1);
    wr(0, 16'hFFFF);
    rd(3, d);
    @(negedge clk); addr = 3; wdata = 16'h0000; wr_en = 1; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
    rd(3, d); chk("R9 set beats clear", d, 16'hFFE3);
    clr_all();
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(4, 16'hFFE8); rd(4, d); chk("R10 enable readback", d, 16'h0008);
    wr(0, 16'h000F); ticks(1);
    wr(0, 16'hFFFF); ticks(1);
    chk("R10 irq A on", {15'h0, irq_cmpa}, 16'h1);
    chk("R10 irq wrap masked", {15'h0, irq_ovf}, 16'h0);
    clr_all();
    chk("R10 irq A off", {15'h0, irq_cmpa}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_compare(); t_wrap(); t_sw_set(); t_arm();
    t_capture(); t_set_wins(); t_irq();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule